// File: doc/BRIEF.md
# Texture Cache Tag Lookup Stage

This block is the front end of a read-only, two-way set-associative texture cache. It takes one pixel read request at a time from an arbiter. A request is a 27-bit pixel address plus a 2-bit client number. The block looks up the tags of the addressed set and decides hit or miss. It then picks a way and rewrites that set's tag, valid and LRU state straight away, without waiting for line data. Tag storage therefore describes where the cache will stand once all queued work has drained.

A miss produces a line-aligned fetch for the memory side. Every request produces one entry for the output queue. That entry tells the downstream data stage which client to answer, whether the line is already resident, and which data-array word to read. A one-cycle invalidate input empties the whole cache. The data array, the memory fabric and any clock-crossing queue live outside this block; it sees them only as push/full queue ports.

Top module: `tex_tag_lookup`

## Requirements
- R1: The pixel address splits, from least to most significant, into a 4-bit pixel offset, a 7-bit set index and a 16-bit tag. A memory fetch carries `mem_addr` = {tag, set}, which equals bits 27..5 of the byte address. It also carries `mem_beats` = 2.
- R2: `req_accepted` is high for exactly one cycle. It rises only while the block is idle, `req_valid` is high, and neither `mem_full` nor `outq_full` is high.
- R3: Exactly one output-queue push follows each acceptance. It occurs two cycles after the acceptance cycle. One request is handled at a time.
- R4: A request whose line is absent is a miss. It pushes an output entry with `outq_hit`=0 and, in the same cycle, one memory fetch.
- R5: A request to a line present in the tag state is a hit, including a line whose miss was just recorded and whose data has not arrived. It pushes an entry with `outq_hit`=1 and no memory fetch.
- R6: The output entry carries the request's client number. It also carries `outq_raddr` = {set(7), way(1), pixel(4)}, with the pixel in bits 3..0 and the way in bit 4.
- R7: A miss fills the way named by its set's LRU bit (0 = way 0, 1 = way 1). Each set keeps its own LRU bit.
- R8: A hit uses the way that hit and sets the set's LRU bit to point at the other way.
- R9: A miss inverts the set's LRU bit, and the chosen way's tag is overwritten, evicting the old line.
- R10: A lookup never finds a hit in both ways at once.
- R11: One clock after `inval` is high, every valid bit is zero, and later requests to formerly resident lines miss. LRU bits are kept.
- R12: After reset every line is invalid, every LRU bit is 0, and no push or acceptance is signalled until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Arbiter has a request |
| req_addr | input | 27 | Pixel address {tag, set, pixel} |
| req_client | input | 2 | Requesting client number |
| req_accepted | output | 1 | One-cycle acceptance pulse |
| inval | input | 1 | Invalidate all lines |
| mem_full | input | 1 | Memory fetch queue full |
| mem_push | output | 1 | Push a line fetch |
| mem_addr | output | 23 | Line-aligned fetch address |
| mem_beats | output | 2 | Number of 128-bit beats to fetch |
| outq_full | input | 1 | Output queue full |
| outq_push | output | 1 | Push an output entry |
| outq_client | output | 2 | Client of the entry |
| outq_hit | output | 1 | 1 = line resident, 0 = miss |
| outq_raddr | output | 12 | Data-array read address {set, way, pixel} |

## Verification
The bench builds a two-line conflict in one set and walks its LRU bit through miss, hit and eviction. A design that chose the LRU from the wrong hit bit, or that left the bit unchanged on a miss, evicts the line just used, and the way bit and hit flag of the later entries come out wrong. A hit issued right after its own miss catches a design that marks lines valid only when data returns: such a design would report a second miss and push a duplicate fetch. The bench also holds each queue full against a waiting request to catch early acceptance. It uses the top set with an all-ones tag to catch field slicing errors in the fetch and read addresses. It invalidates and then revisits resident lines to catch a stale valid bit or a wrongly cleared LRU bit.

// File: rtl/tex_tag_lookup.sv
module tex_tag_lookup #(
  parameter int TAG_W = 16,
  parameter int SET_W = 7,
  parameter int OFF_W = 4,
  parameter int BEATS = 2,
  localparam int ADDR_W  = TAG_W + SET_W + OFF_W,
  localparam int NSETS   = 1 << SET_W,
  localparam int RADDR_W = SET_W + 1 + OFF_W,
  localparam int MADDR_W = TAG_W + SET_W,
  localparam int BEAT_W  = $clog2(BEATS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_client,
  output logic               req_accepted,
  input  logic               inval,
  input  logic               mem_full,
  output logic               mem_push,
  output logic [MADDR_W-1:0] mem_addr,
  output logic [BEAT_W-1:0]  mem_beats,
  input  logic               outq_full,
  output logic               outq_push,
  output logic [1:0]         outq_client,
  output logic               outq_hit,
  output logic [RADDR_W-1:0] outq_raddr
);
  typedef enum logic [1:0] {ST_TAKE, ST_LOOK, ST_WRITE} st_t;
  st_t st;

  logic [ADDR_W-1:0] cur_addr;
  logic [1:0]        cur_client;
  logic [TAG_W-1:0]  tag0 [NSETS];
  logic [TAG_W-1:0]  tag1 [NSETS];
  logic [NSETS-1:0]  vld0, vld1, lru;
  logic [TAG_W-1:0]  rd_tag0, rd_tag1;
  logic              rd_v0, rd_v1, rd_lru;
  logic [1:0]        hit;
  logic              way;

  wire [OFF_W-1:0] cur_pix = cur_addr[OFF_W-1:0];
  wire [SET_W-1:0] cur_set = cur_addr[OFF_W +: SET_W];
  wire [TAG_W-1:0] cur_tag = cur_addr[ADDR_W-1 -: TAG_W];
  wire             upd     = (st == ST_WRITE);

  assign req_accepted = (st == ST_TAKE) && req_valid && !mem_full && !outq_full;
  assign hit[0] = rd_v0 && (rd_tag0 == cur_tag);
  assign hit[1] = rd_v1 && (rd_tag1 == cur_tag);
  assign way    = (|hit) ? hit[1] : rd_lru;

  assign outq_push   = upd;
  assign outq_client = cur_client;
  assign outq_hit    = |hit;
  assign outq_raddr  = {cur_set, way, cur_pix};
  assign mem_push    = upd && !(|hit);
  assign mem_addr    = {cur_tag, cur_set};
  assign mem_beats   = BEAT_W'(BEATS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_TAKE;
      cur_addr   <= '0;
      cur_client <= '0;
      rd_tag0    <= '0;
      rd_tag1    <= '0;
      rd_v0      <= 1'b0;
      rd_v1      <= 1'b0;
      rd_lru     <= 1'b0;
    end else begin
      case (st)
        ST_TAKE: if (req_accepted) begin
          cur_addr   <= req_addr;
          cur_client <= req_client;
          st         <= ST_LOOK;
        end
        ST_LOOK: begin
          rd_tag0 <= tag0[cur_set];
          rd_tag1 <= tag1[cur_set];
          rd_v0   <= vld0[cur_set] && !inval;
          rd_v1   <= vld1[cur_set] && !inval;
          rd_lru  <= lru[cur_set];
          st      <= ST_WRITE;
        end
        default: st <= ST_TAKE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (upd && !way) tag0[cur_set] <= cur_tag;
    if (upd &&  way) tag1[cur_set] <= cur_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld0 <= '0;
      vld1 <= '0;
      lru  <= '0;
    end else begin
      if (upd) begin
        lru[cur_set] <= (|hit) ? hit[0] : ~rd_lru;
        if (way) vld1[cur_set] <= 1'b1;
        else     vld0[cur_set] <= 1'b1;
      end
      if (inval) begin
        vld0 <= '0;
        vld1 <= '0;
      end
    end
  end
endmodule

module tex_tag_lookup_chk #(
  parameter int NSETS  = 128,
  parameter int BEAT_W = 2,
  parameter int BEATS  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_accepted,
  input logic              mem_full,
  input logic              outq_full,
  input logic              inval,
  input logic              mem_push,
  input logic [BEAT_W-1:0] mem_beats,
  input logic              outq_push,
  input logic              outq_hit,
  input logic [1:0]        hit_vec,
  input logic [NSETS-1:0]  vld0,
  input logic [NSETS-1:0]  vld1
);
  AST_FETCH_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_push |-> mem_beats == BEAT_W'(BEATS)); // R1
  AST_ACCEPT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_accepted |=> !req_accepted); // R2
  AST_NO_ACCEPT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_full || outq_full) |-> !req_accepted); // R2
  AST_PUSH_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_accepted |=> !outq_push ##1 outq_push); // R3
  AST_MISS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_push |-> (outq_push && !outq_hit)); // R4
  AST_HIT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (outq_push && outq_hit) |-> !mem_push); // R5
  AST_HIT_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R10
  AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    inval |=> (vld0 == '0 && vld1 == '0)); // R11
endmodule

bind tex_tag_lookup tex_tag_lookup_chk #(
  .NSETS(NSETS), .BEAT_W(BEAT_W), .BEATS(BEATS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_accepted(req_accepted),
  .mem_full(mem_full), .outq_full(outq_full), .inval(inval),
  .mem_push(mem_push), .mem_beats(mem_beats), .outq_push(outq_push),
  .outq_hit(outq_hit), .hit_vec(hit), .vld0(vld0), .vld1(vld1)
);

// File: tb/sim_tex_tag_lookup.sv
module sim_tex_tag_lookup;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [26:0] req_addr = '0;
  logic [1:0]  req_client = '0;
  logic        req_accepted;
  logic        inval = 1'b0;
  logic        mem_full = 1'b0;
  logic        mem_push;
  logic [22:0] mem_addr;
  logic [1:0]  mem_beats;
  logic        outq_full = 1'b0;
  logic        outq_push;
  logic [1:0]  outq_client;
  logic        outq_hit;
  logic [11:0] outq_raddr;

  tex_tag_lookup u0 (.*);

  always #10 clk = ~clk;

  typedef struct {
    logic [26:0] a;
    logic [1:0]  c;
    bit          h;
    bit          w;
    int          cyc;
    string       r;
  } exp_t;
  exp_t q[$];

  int cyc = 0, checks = 0, fails = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string r, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  function automatic logic [26:0] mk(input logic [15:0] t, input logic [6:0] s, input logic [3:0] p);
    return {t, s, p};
  endfunction

  task automatic push_exp(input logic [26:0] a, input logic [1:0] c, input bit h, input bit w, input string r);
    exp_t e;
    e.a = a; e.c = c; e.h = h; e.w = w; e.cyc = cyc; e.r = r;
    q.push_back(e);
  endtask

  task automatic send(input logic [26:0] a, input logic [1:0] c, input bit h, input bit w, input string r);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_client = c;
    #1;
    while (!req_accepted) begin @(negedge clk); #1; end
    push_exp(a, c, h, w, r);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (outq_push) begin
        if (q.size() == 0) chk(1'b0, "R3", "unexpected push", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(outq_hit == e.h, e.h ? "R5" : "R4", "hit flag", outq_hit, e.h);
          chk(outq_raddr[4] == e.w, e.r, "way", outq_raddr[4], e.w);
          chk(outq_raddr == {e.a[10:4], e.w, e.a[3:0]}, "R6", "read address", outq_raddr, {e.a[10:4], e.w, e.a[3:0]});
          chk(outq_client == e.c, "R6", "client", outq_client, e.c);
          chk(cyc == e.cyc + 2, "R3", "latency", cyc - e.cyc, 2);
          chk(mem_push == !e.h, e.h ? "R5" : "R4", "fetch push", mem_push, !e.h);
          if (!e.h) begin
            chk(mem_addr == e.a[26:4], "R1", "fetch address", mem_addr, e.a[26:4]);
            chk(mem_beats == 2'd2, "R1", "beats", mem_beats, 2);
          end
        end
      end else if (mem_push) chk(1'b0, "R4", "fetch without entry", 1, 0);
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    chk(1'b0, "R3", "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!outq_push && !mem_push && !req_accepted, "R12", "quiet after reset", {outq_push, mem_push, req_accepted}, 0);

    send(mk(16'h0011, 7'd0, 4'd3), 2'd0, 1'b0, 1'b0, "R12");
    send(mk(16'h0011, 7'd0, 4'd5), 2'd1, 1'b1, 1'b0, "R5");
    send(mk(16'h0022, 7'd0, 4'd1), 2'd2, 1'b0, 1'b1, "R7");
    send(mk(16'h0011, 7'd0, 4'd0), 2'd3, 1'b1, 1'b0, "R8");
    send(mk(16'h0022, 7'd0, 4'd9), 2'd0, 1'b1, 1'b1, "R8");
    send(mk(16'h0033, 7'd0, 4'd2), 2'd1, 1'b0, 1'b0, "R9");
    send(mk(16'h0011, 7'd0, 4'd4), 2'd2, 1'b0, 1'b1, "R9");
    send(mk(16'h0033, 7'd0, 4'd6), 2'd3, 1'b1, 1'b0, "R5");
    send(mk(16'h0011, 7'd5, 4'd7), 2'd0, 1'b0, 1'b0, "R7");
    send(mk(16'hFFFF, 7'd127, 4'd15), 2'd1, 1'b0, 1'b0, "R1");
    send(mk(16'hFFFF, 7'd127, 4'd0), 2'd2, 1'b1, 1'b0, "R6");

    // R2: fetch queue full holds off acceptance
    @(negedge clk);
    mem_full = 1'b1; req_valid = 1'b1; req_addr = mk(16'h0444, 7'd9, 4'd1); req_client = 2'd3;
    #1;
    for (int i = 0; i < 4; i++) begin
      chk(!req_accepted, "R2", "accepted while fetch queue full", req_accepted, 0);
      @(negedge clk); #1;
    end
    mem_full = 1'b0; #1;
    chk(req_accepted, "R2", "accept after release", req_accepted, 1);
    push_exp(req_addr, 2'd3, 1'b0, 1'b0, "R7");
    @(negedge clk); #1;
    chk(!req_accepted, "R2", "pulse width", req_accepted, 0);
    req_valid = 1'b0;

    // R2: output queue full holds off acceptance
    @(negedge clk);
    outq_full = 1'b1; req_valid = 1'b1; req_addr = mk(16'h0555, 7'd10, 4'd2); req_client = 2'd2;
    #1;
    for (int i = 0; i < 4; i++) begin
      chk(!req_accepted, "R2", "accepted while output queue full", req_accepted, 0);
      @(negedge clk); #1;
    end
    outq_full = 1'b0; #1;
    chk(req_accepted, "R2", "accept after release", req_accepted, 1);
    push_exp(req_addr, 2'd2, 1'b0, 1'b0, "R7");
    @(negedge clk);
    req_valid = 1'b0;

    // R11: invalidate, LRU retained
    repeat (3) @(negedge clk);
    inval = 1'b1;
    @(negedge clk);
    inval = 1'b0;
    send(mk(16'h0033, 7'd0, 4'd6), 2'd0, 1'b0, 1'b1, "R11");
    send(mk(16'h0033, 7'd0, 4'd7), 2'd1, 1'b1, 1'b1, "R11");
    send(mk(16'hFFFF, 7'd127, 4'd15), 2'd2, 1'b0, 1'b1, "R11");

    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule